// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Register Bank

This block holds 256 byte-wide configuration registers for a chipset and reaches them through a pair of I/O ports. A write to the index port chooses one register. A later access to the data port reads or writes that register. Software must first write a key byte to a dedicated lock index before any data write takes effect. Each register then applies its own write rule: the full byte, a fixed bit mask, no write at all, or set-only accumulation.

The whole register image goes out on a flat bus for downstream decode logic. One derived select, the disk-base choice, also has a pin of its own. The bus is a simple synchronous strobe interface. A single address bit picks the port, and decoding of the wider I/O space happens elsewhere.

Top module: `cfg_bank`

## Requirements
- R1: A write with `io_addr`=0 loads the index from `io_wdata`. A read with `io_addr`=0 returns the current index.
- R2: A data write (`io_addr`=1) while the index is 0x13 unlocks the bank when the byte is 0xC5. Any other byte at that index locks the bank. Register 0x13 itself is never written and reads 0x00.
- R3: While the bank is locked, data writes to any index other than 0x13 change no register.
- R4: A read with `io_addr`=1 returns the selected register whether the bank is locked or not. `io_rdata` is 0x00 whenever `io_rd` is low.
- R5: Indices 0x30, 0x34, 0x35, 0x3E, 0x3F, 0x46, 0x4C, 0x6A and 0x73 are read-only. Data writes to them have no effect, even when the bank is unlocked.
- R6: Unlocked writes store the written byte ANDed with a per-index mask: 0x12 uses F7, 0x1E uses 07, 0x20 uses BF, 0x31 uses 21, 0x32 uses C1, 0x33 uses FD, 0x37 uses F5, 0x3C uses 8F, and 0x44 and 0x45 use 3F.
- R7: An unlocked write to index 0x36 ORs the upper nibble of the written byte into the register. Bits already set there never clear.
- R8: Any other unlocked writable index stores the full written byte.
- R9: After reset the index is 0x00 and the bank is locked. Registers 0x11=F8, 0x12=20, 0x17=FF, 0x18=F0, 0x1A=FF, 0x1B=F0, 0x1D=FF, 0x20=80, 0x30=08, 0x31=01, 0x34=04 and 0x35=20. Every other register is 0x00.
- R10: `regs_flat[8*i+7:8*i]` always equals register i. `disk_sec_sel` equals bit 0 of register 0x3C (1 selects the secondary disk base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 1 | Port select: 0 = index port, 1 = data port |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not reading |
| regs_flat | output | 2048 | All registers, register i in byte lane i |
| disk_sec_sel | output | 1 | Disk base select, 1 = secondary |

## Verification
The assertions watch, on every cycle, the index load, the key outcome and the frozen image after locked writes. They also check that read-only indices keep their value, that masked-off bits of register 0x12 and register 0x1E stay zero, and that the sticky register never loses a bit. Only the bench scenarios can show the exact reset image of all 256 registers. The same holds for the stored value after each mask, the full-byte store of unlisted indices, and the read path under both lock states. A behavioural model in the bench runs through these and compares the outputs on every clock.

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int NREGS = 256,
  parameter int DW = 8,
  parameter logic [7:0] KEY_IDX = 8'h13,
  parameter logic [7:0] KEY_VAL = 8'hC5,
  parameter logic [7:0] STICKY_IDX = 8'h36,
  parameter logic [7:0] DISK_IDX = 8'h3C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_addr,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [DW-1:0]         io_wdata,
  output logic [DW-1:0]         io_rdata,
  output logic [NREGS*DW-1:0]   regs_flat,
  output logic                  disk_sec_sel
);
  localparam int IW = $clog2(NREGS);

  logic [DW-1:0] regs [NREGS];
  logic [IW-1:0] idx;
  logic          unlocked;
  logic [DW-1:0] cur, next_val;

  function automatic logic [DW-1:0] init_of(input logic [IW-1:0] a);
    case (a)
      8'h11: init_of = 8'hF8;
      8'h12: init_of = 8'h20;
      8'h17: init_of = 8'hFF;
      8'h18: init_of = 8'hF0;
      8'h1A: init_of = 8'hFF;
      8'h1B: init_of = 8'hF0;
      8'h1D: init_of = 8'hFF;
      8'h20: init_of = 8'h80;
      8'h30: init_of = 8'h08;
      8'h31: init_of = 8'h01;
      8'h34: init_of = 8'h04;
      8'h35: init_of = 8'h20;
      default: init_of = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] mask_of(input logic [IW-1:0] a);
    case (a)
      8'h12: mask_of = 8'hF7;
      8'h1E: mask_of = 8'h07;
      8'h20: mask_of = 8'hBF;
      8'h31: mask_of = 8'h21;
      8'h32: mask_of = 8'hC1;
      8'h33: mask_of = 8'hFD;
      8'h37: mask_of = 8'hF5;
      8'h3C: mask_of = 8'h8F;
      8'h44, 8'h45: mask_of = 8'h3F;
      default: mask_of = '1;
    endcase
  endfunction

  function automatic logic read_only(input logic [IW-1:0] a);
    case (a)
      8'h30, 8'h34, 8'h35, 8'h3E, 8'h3F,
      8'h46, 8'h4C, 8'h6A, 8'h73: read_only = 1'b1;
      default: read_only = 1'b0;
    endcase
  endfunction

  assign cur = regs[idx];
  assign next_val = (idx == STICKY_IDX) ? ((io_wdata & 8'hF0) | cur)
                                        : (io_wdata & mask_of(idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      unlocked <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= init_of(IW'(i));
    end else if (io_wr) begin
      if (!io_addr)
        idx <= io_wdata;
      else if (idx == KEY_IDX)
        unlocked <= (io_wdata == KEY_VAL);
      else if (unlocked && !read_only(idx))
        regs[idx] <= next_val;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = regs[g];
  end

  assign io_rdata     = !io_rd ? '0 : (io_addr ? cur : idx);
  assign disk_sec_sel = regs[DISK_IDX][0];
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk (
  input logic          clk,
  input logic          rst_n,
  input logic          io_addr,
  input logic          io_wr,
  input logic [7:0]    io_wdata,
  input logic [7:0]    idx,
  input logic          unlocked,
  input logic [2047:0] regs_flat
);
  logic dwr;
  assign dwr = io_wr && io_addr;

  assert_index_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && !io_addr |=> idx == $past(io_wdata));

  assert_key_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && idx == 8'h13 |=> unlocked == ($past(io_wdata) == 8'hC5));

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && !unlocked |=> $stable(regs_flat));

  assert_ro_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && (idx inside {8'h30, 8'h34, 8'h35, 8'h3E, 8'h3F, 8'h46, 8'h4C, 8'h6A, 8'h73})
    |=> $stable(regs_flat));

  assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[8'h12*8+3] == 1'b0 && regs_flat[8'h1E*8+3 +: 5] == 5'd0);

  assert_sticky_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dwr && idx == 8'h36 |=> ($past(regs_flat[8'h36*8 +: 8]) & ~regs_flat[8'h36*8 +: 8]) == 8'h00);
endmodule

bind cfg_bank cfg_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_wdata(io_wdata), .idx(idx), .unlocked(unlocked), .regs_flat(regs_flat)
);

// File: tb/cfg_bank_tb_top.sv
`timescale 1ns/1ps
module cfg_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic io_addr = 0, io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = 0;
  logic [7:0] io_rdata;
  logic [2047:0] regs_flat;
  logic disk_sec_sel;
  int checks = 0, errors = 0;

  int m [256];
  int midx;
  bit mlock;
  int ro_q[$] = '{'h30, 'h34, 'h35, 'h3E, 'h3F, 'h46, 'h4C, 'h6A, 'h73};
  int mask_a[int];
  int init_a[int];

  always #2 clk = ~clk;

  cfg_bank dut_i (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .regs_flat(regs_flat), .disk_sec_sel(disk_sec_sel));

  function automatic bit is_ro(int a);
    foreach (ro_q[k]) if (ro_q[k] == a) return 1;
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m[i] = init_a.exists(i) ? init_a[i] : 0;
    midx = 0; mlock = 0;
  endtask

  task automatic compare(string tag);
    int exp_rd;
    int bad;
    exp_rd = !io_rd ? 0 : (io_addr ? m[midx] : midx);
    checks++;
    if (io_rdata !== exp_rd[7:0]) begin
      errors++;
      $display("FAIL %s rdata act=%02h exp=%02h", tag, io_rdata, exp_rd[7:0]);
    end
    checks++;
    bad = -1;
    for (int i = 0; i < 256; i++)
      if (bad < 0 && regs_flat[i*8 +: 8] !== m[i][7:0]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s reg %02h act=%02h exp=%02h", tag, bad, regs_flat[bad*8 +: 8], m[bad][7:0]);
    end
    checks++;
    if (disk_sec_sel !== m['h3C][0]) begin
      errors++;
      $display("FAIL R10 disk_sec_sel act=%0b exp=%0b", disk_sec_sel, m['h3C][0]);
    end
  endtask

  task automatic step(bit a, bit wr, bit rd, int wd, string tag);
    io_addr = a; io_wr = wr; io_rd = rd; io_wdata = wd[7:0];
    #1;
    compare(tag);
    @(posedge clk);
    if (wr) begin
      if (!a) midx = wd & 'hFF;
      else if (midx == 'h13) mlock = (wd == 'hC5);
      else if (mlock && !is_ro(midx)) begin
        if (midx == 'h36) m[midx] = m[midx] | (wd & 'hF0);
        else m[midx] = wd & (mask_a.exists(midx) ? mask_a[midx] : 'hFF);
      end
    end
    @(negedge clk);
  endtask

  task automatic wreg(int a, int v, string tag);
    step(0, 1, 0, a, tag);
    step(1, 1, 0, v, tag);
    step(1, 0, 1, 0, tag);
  endtask

  initial begin
    init_a = '{'h11:'hF8, 'h12:'h20, 'h17:'hFF, 'h18:'hF0, 'h1A:'hFF, 'h1B:'hF0,
               'h1D:'hFF, 'h20:'h80, 'h30:'h08, 'h31:'h01, 'h34:'h04, 'h35:'h20};
    mask_a = '{'h12:'hF7, 'h1E:'h07, 'h20:'hBF, 'h31:'h21, 'h32:'hC1, 'h33:'hFD,
               'h37:'hF5, 'h3C:'h8F, 'h44:'h3F, 'h45:'h3F};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    step(0, 0, 1, 0, "R9");
    for (int i = 0; i < 256; i++) begin
      step(0, 1, 0, i, "R1");
      step(1, 0, 1, 0, "R9");
    end
    step(1, 0, 0, 0, "R4");
    wreg('h11, 'h5A, "R3");
    wreg('h13, 'h12, "R2");
    wreg('h20, 'h00, "R3");
    wreg('h13, 'hC5, "R2");
    step(1, 0, 1, 0, "R2");
    wreg('h50, 'hA5, "R8");
    wreg('h11, 'h3C, "R8");
    foreach (mask_a[k]) wreg(k, 'hFF, "R6");
    wreg('h12, 'h08, "R6");
    foreach (ro_q[k]) wreg(ro_q[k], 'hFF, "R5");
    wreg('h36, 'hF3, "R7");
    wreg('h36, 'h00, "R7");
    wreg('h36, 'h5F, "R7");
    wreg('h3C, 'h01, "R10");
    wreg('h3C, 'h00, "R10");
    wreg('h3C, 'hFE, "R10");
    wreg('h13, 'h00, "R2");
    wreg('h50, 'h11, "R3");
    wreg('h36, 'hFF, "R3");
    step(0, 1, 0, 'hAB, "R1");
    step(0, 0, 1, 0, "R1");
    step(1, 0, 1, 0, "R4");
    wreg('h13, 'hC5, "R2");
    wreg('hFF, 'h77, "R8");
    step(1, 0, 0, 0, "R4");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule